// File: doc/BRIEF.md
# Interrupt Priority Level Arbiter

This block decides whether a pending interrupt should interrupt the processor. On each evaluate strobe it examines two request vectors. One holds software-posted requests and the other holds external interrupt lines. From the requests that fall inside their configured bit ranges it derives a single priority level and a bitmask that summarises every pending request. It then compares that level against the processor's current priority level. If the level is higher, the block latches the summary mask and the level into its summary and identifier registers and emits a one-cycle trap request.

The asynchronous-trap request input is not arbitrated. A nonzero value on it during a strobe produces a one-cycle unsupported-condition pulse, and the strobe is otherwise ignored. A sticky check flag records that requests have been seen since the last evaluation, and every strobe clears it.

Top module: `ipl_arbiter`

## Requirements
- R1: A set bit i of `soft_req_i` with SW_LO <= i <= SW_HI (defaults 1 and 15) gives candidate level i - SW_LO + 1. Bit 1 gives level 1 and bit 15 gives level 15.
- R2: A set bit i of `ext_req_i` with EXT_LO <= i <= EXT_HI (defaults 16 and 30) gives candidate level i. Bit 16 gives 16 and bit 30 gives 30.
- R3: The level is the candidate of the highest pending software bit, unless any external bit is pending. In that case it is the candidate of the highest pending external bit, so external requests always win.
- R4: The summary mask has bit i set exactly when bit i is pending inside its own range, in either vector. Bits outside both ranges (bit 0 and bit 31 by default) never affect the level or the mask.
- R5: An interrupt is taken only on a strobe where the level is nonzero and strictly greater than `cur_ipl_i`. An equal level is not taken.
- R6: After a taken strobe, on the next clock edge `summary_o` holds the mask, `int_id_o` holds the level, and `trap_o` is high for exactly that one cycle.
- R7: A strobe that is not taken, or a cycle without a strobe, leaves `summary_o` and `int_id_o` unchanged and keeps `trap_o` low.
- R8: A strobe while `async_req_i` is nonzero makes `unsup_o` high for one cycle after the edge. It raises no trap and changes neither register.
- R9: `chk_pend_o` becomes 1 after an edge without a strobe at which an in-range request or a nonzero `async_req_i` was present. It remains set until the edge after the next strobe, which clears it.
- R10: A synchronous active-high `rst` clears `summary_o`, `int_id_o`, `trap_o`, `unsup_o` and `chk_pend_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Evaluate strobe |
| soft_req_i | input | REQ_W | Software request bits |
| ext_req_i | input | REQ_W | External interrupt request lines |
| async_req_i | input | REQ_W | Asynchronous-trap request value (unsupported when nonzero) |
| cur_ipl_i | input | LVL_W | Current processor priority level |
| summary_o | output | REQ_W | Registered summary of pending requests |
| int_id_o | output | LVL_W | Registered level of the taken interrupt |
| trap_o | output | 1 | One-cycle trap request |
| unsup_o | output | 1 | One-cycle unsupported-condition pulse |
| chk_pend_o | output | 1 | Sticky check-pending flag |

## Verification
The bench builds the block with its default parameters: a 32-bit request space, software bits 1 to 15, external bits 16 to 30, and 5-bit levels. With these values both boundary bits of each range are reachable, as are the out-of-range bits 0 and 31. The transition at bit 16, where a software level of 15 meets an external level of 16, can be exercised against a current level of 15. The stimulus table covers the equal-level refusal, external override and full-vector masks, while directed steps cover the unsupported path, the check flag and reset.

// File: rtl/ipl_arb_pkg.sv
package ipl_arb_pkg;

  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_TAKE    = 2'd1,
    EV_DECLINE = 2'd2,
    EV_UNSUP   = 2'd3
  } eval_kind_e;

  // Level carried by a software bit: position relative to range start, plus one.
  function automatic int sw_bit_level(input int bit_idx, input int range_lo);
    return bit_idx - range_lo + 1;
  endfunction

  // Level carried by an external bit: its own position.
  function automatic int ext_bit_level(input int bit_idx);
    return bit_idx;
  endfunction

  function automatic bit in_range(input int bit_idx, input int lo, input int hi);
    return (bit_idx >= lo) && (bit_idx <= hi);
  endfunction

endpackage

// File: rtl/ipl_level_scan.sv
module ipl_level_scan
  import ipl_arb_pkg::*;
#(
  parameter int REQ_W  = 32,
  parameter int SW_LO  = 1,
  parameter int SW_HI  = 15,
  parameter int EXT_LO = 16,
  parameter int EXT_HI = 30,
  parameter int LVL_W  = 5
) (
  input  logic [REQ_W-1:0] soft_req,
  input  logic [REQ_W-1:0] ext_req,
  output logic [LVL_W-1:0] level,
  output logic [REQ_W-1:0] summary,
  output logic             any_hit
);

  logic [REQ_W-1:0] sw_hit;
  logic [REQ_W-1:0] ext_hit;
  logic [LVL_W-1:0] sw_lvl  [REQ_W];
  logic [LVL_W-1:0] ext_lvl [REQ_W];

  // Per-bit qualification and candidate level
  for (genvar g = 0; g < REQ_W; g++) begin : g_bit
    if (in_range(g, SW_LO, SW_HI)) begin : g_sw
      assign sw_hit[g] = soft_req[g];
      assign sw_lvl[g] = LVL_W'(sw_bit_level(g, SW_LO));
    end else begin : g_sw_off
      assign sw_hit[g] = 1'b0;
      assign sw_lvl[g] = '0;
    end
    if (in_range(g, EXT_LO, EXT_HI)) begin : g_ext
      assign ext_hit[g] = ext_req[g];
      assign ext_lvl[g] = LVL_W'(ext_bit_level(g));
    end else begin : g_ext_off
      assign ext_hit[g] = 1'b0;
      assign ext_lvl[g] = '0;
    end
  end

  // Ascending scan, software first then external: the last hit wins.
  always_comb begin
    level = '0;
    for (int i = 0; i < REQ_W; i++) begin
      if (sw_hit[i]) level = sw_lvl[i];
    end
    for (int i = 0; i < REQ_W; i++) begin
      if (ext_hit[i]) level = ext_lvl[i];
    end
  end

  assign summary = sw_hit | ext_hit;
  assign any_hit = |summary;

  always_comb begin
    if (|ext_hit) begin
      AST_EXT_OVERRIDES: assert (int'(level) >= EXT_LO); // R3
    end
    if (|summary) begin
      AST_HIT_GIVES_LEVEL: assert (level != '0); // R4
    end
  end

endmodule

// File: rtl/ipl_take_decide.sv
module ipl_take_decide
  import ipl_arb_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             eval,
  input  logic             async_nz,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] cur_ipl,
  output eval_kind_e       kind
);

  logic beats;
  assign beats = (level != '0) && (level > cur_ipl);

  always_comb begin
    if (!eval)         kind = EV_NONE;
    else if (async_nz) kind = EV_UNSUP;
    else if (beats)    kind = EV_TAKE;
    else               kind = EV_DECLINE;
  end

  always_comb begin
    if (kind == EV_TAKE) begin
      AST_TAKE_STRICT: assert (level > cur_ipl); // R5
    end
  end

endmodule

// File: rtl/ipl_trap_regs.sv
module ipl_trap_regs
  import ipl_arb_pkg::*;
#(
  parameter int REQ_W = 32,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  eval_kind_e       kind,
  input  logic             seen_req,
  input  logic [REQ_W-1:0] summary_in,
  input  logic [LVL_W-1:0] level_in,
  output logic [REQ_W-1:0] summary_q,
  output logic [LVL_W-1:0] id_q,
  output logic             trap_q,
  output logic             unsup_q,
  output logic             chk_q
);

  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      summary_q <= '0;
      id_q      <= '0;
      trap_q    <= 1'b0;
      unsup_q   <= 1'b0;
      chk_q     <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      trap_q  <= (kind == EV_TAKE);
      unsup_q <= (kind == EV_UNSUP);
      if (kind == EV_TAKE) begin
        summary_q <= summary_in;
        id_q      <= level_in;
      end
      if (kind != EV_NONE) chk_q <= 1'b0;
      else if (seen_req)   chk_q <= 1'b1;
    end
  end

  AST_HOLD_WITHOUT_TRAP: assert property (@(posedge clk) disable iff (rst || !armed_q)
    !trap_q |-> ($stable(summary_q) && $stable(id_q))); // R7
  AST_UNSUP_NO_TRAP: assert property (@(posedge clk) disable iff (rst || !armed_q)
    !(trap_q && unsup_q)); // R8
  AST_TRAP_HAS_CONTENT: assert property (@(posedge clk) disable iff (rst || !armed_q)
    trap_q |-> ((summary_q != '0) && (id_q != '0))); // R6

endmodule

// File: rtl/ipl_arbiter.sv
module ipl_arbiter
  import ipl_arb_pkg::*;
#(
  parameter int REQ_W  = 32,
  parameter int SW_LO  = 1,
  parameter int SW_HI  = 15,
  parameter int EXT_LO = 16,
  parameter int EXT_HI = 30,
  parameter int LVL_W  = $clog2(EXT_HI + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eval_i,
  input  logic [REQ_W-1:0] soft_req_i,
  input  logic [REQ_W-1:0] ext_req_i,
  input  logic [REQ_W-1:0] async_req_i,
  input  logic [LVL_W-1:0] cur_ipl_i,
  output logic [REQ_W-1:0] summary_o,
  output logic [LVL_W-1:0] int_id_o,
  output logic             trap_o,
  output logic             unsup_o,
  output logic             chk_pend_o
);

  logic [LVL_W-1:0] scan_level;
  logic [REQ_W-1:0] scan_summary;
  logic             scan_any;
  logic             async_nz;
  eval_kind_e       eval_kind;

  assign async_nz = |async_req_i;

  ipl_level_scan #(
    .REQ_W(REQ_W), .SW_LO(SW_LO), .SW_HI(SW_HI),
    .EXT_LO(EXT_LO), .EXT_HI(EXT_HI), .LVL_W(LVL_W)
  ) u_scan (
    .soft_req (soft_req_i),
    .ext_req  (ext_req_i),
    .level    (scan_level),
    .summary  (scan_summary),
    .any_hit  (scan_any)
  );

  ipl_take_decide #(.LVL_W(LVL_W)) u_decide (
    .eval     (eval_i),
    .async_nz (async_nz),
    .level    (scan_level),
    .cur_ipl  (cur_ipl_i),
    .kind     (eval_kind)
  );

  ipl_trap_regs #(.REQ_W(REQ_W), .LVL_W(LVL_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .kind       (eval_kind),
    .seen_req   (scan_any || async_nz),
    .summary_in (scan_summary),
    .level_in   (scan_level),
    .summary_q  (summary_o),
    .id_q       (int_id_o),
    .trap_q     (trap_o),
    .unsup_q    (unsup_o),
    .chk_q      (chk_pend_o)
  );

  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  AST_TRAP_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst || !armed_q)
    trap_o |-> $past(eval_i)); // R6
  AST_TRAP_ABOVE_IPL: assert property (@(posedge clk) disable iff (rst || !armed_q)
    trap_o |-> (int_id_o > $past(cur_ipl_i))); // R5
  AST_UNSUP_NEEDS_ASYNC: assert property (@(posedge clk) disable iff (rst || !armed_q)
    unsup_o |-> ($past(eval_i) && ($past(async_req_i) != '0))); // R8
  AST_STROBE_CLEARS_CHK: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $past(eval_i) |-> !chk_pend_o); // R9

endmodule

// File: tb/ipl_arbiter_test.sv
module ipl_arbiter_test;

  localparam int REQ_W = 32;
  localparam int LVL_W = 5;
  localparam int NV    = 12;

  logic             clk = 1'b0;
  logic             rst;
  logic             eval_i;
  logic [REQ_W-1:0] soft_req_i, ext_req_i, async_req_i;
  logic [LVL_W-1:0] cur_ipl_i;
  logic [REQ_W-1:0] summary_o;
  logic [LVL_W-1:0] int_id_o;
  logic             trap_o, unsup_o, chk_pend_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ipl_arbiter uut (
    .clk(clk), .rst(rst), .eval_i(eval_i),
    .soft_req_i(soft_req_i), .ext_req_i(ext_req_i), .async_req_i(async_req_i),
    .cur_ipl_i(cur_ipl_i), .summary_o(summary_o), .int_id_o(int_id_o),
    .trap_o(trap_o), .unsup_o(unsup_o), .chk_pend_o(chk_pend_o)
  );

  // Stimulus table: software bits, external bits, current level, expected take, expected level
  localparam logic [31:0] T_SOFT [NV] = '{
    32'h0000_0002, 32'h0000_8000, 32'h0000_8000, 32'h0000_0001,
    32'h0000_0006, 32'h0000_8002, 32'h0000_0000, 32'h0000_0000,
    32'h0000_0000, 32'h0000_0010, 32'h0000_0010, 32'h0000_FFFE };
  localparam logic [31:0] T_EXT [NV] = '{
    32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
    32'h0000_0000, 32'h0001_0000, 32'h4000_0000, 32'h8000_0000,
    32'h0005_0000, 32'h0000_0000, 32'h0000_0000, 32'h7FFF_0000 };
  localparam logic [4:0] T_IPL [NV] = '{
    5'd0, 5'd14, 5'd15, 5'd0, 5'd0, 5'd15, 5'd29, 5'd0, 5'd20, 5'd3, 5'd31, 5'd0 };
  localparam logic T_TAKE [NV] = '{
    1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1 };
  localparam logic [4:0] T_LVL [NV] = '{
    5'd1, 5'd15, 5'd15, 5'd0, 5'd2, 5'd16, 5'd30, 5'd0, 5'd18, 5'd4, 5'd4, 5'd30 };

  // Bench-side mask of the in-range bits (R4): software 1..15, external 16..30
  function automatic logic [31:0] ref_mask(input logic [31:0] s, input logic [31:0] e);
    return (s & 32'h0000_FFFE) | (e & 32'h7FFF_0000);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic strobe(input logic [31:0] s, input logic [31:0] e, input logic [31:0] a, input logic [4:0] ipl);
    soft_req_i = s; ext_req_i = e; async_req_i = a; cur_ipl_i = ipl; eval_i = 1'b1;
    @(posedge clk); @(negedge clk);
    eval_i = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_sum;
    logic [4:0]  exp_id;
    rst = 1'b1; eval_i = 1'b0; soft_req_i = '0; ext_req_i = '0; async_req_i = '0; cur_ipl_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10", "summary after reset", summary_o, 32'h0);
    chk("R10", "id after reset", 32'(int_id_o), 32'h0);
    chk("R10", "trap after reset", 32'(trap_o), 32'h0);
    chk("R10", "chk after reset", 32'(chk_pend_o), 32'h0);

    exp_sum = '0; exp_id = '0;
    // R1 R2 R3 R4 R5 R6 R7: table walk
    for (int v = 0; v < NV; v++) begin
      strobe(T_SOFT[v], T_EXT[v], 32'h0, T_IPL[v]);
      if (T_TAKE[v]) begin
        exp_sum = ref_mask(T_SOFT[v], T_EXT[v]);
        exp_id  = T_LVL[v];
      end
      chk("R5", $sformatf("take vec %0d", v), 32'(trap_o), 32'(T_TAKE[v]));
      chk("R6", $sformatf("id vec %0d", v), 32'(int_id_o), 32'(exp_id));
      chk("R4", $sformatf("summary vec %0d", v), summary_o, exp_sum);
      @(posedge clk); @(negedge clk);
      chk("R6", $sformatf("trap pulse end vec %0d", v), 32'(trap_o), 32'h0);
      chk("R7", $sformatf("hold id vec %0d", v), 32'(int_id_o), 32'(exp_id));
    end

    // R8: async request on a strobe that would otherwise be taken
    strobe(32'h0000_0002, 32'h0, 32'h0000_0004, 5'd0);
    chk("R8", "unsup pulse", 32'(unsup_o), 32'h1);
    chk("R8", "no trap", 32'(trap_o), 32'h0);
    chk("R8", "summary held", summary_o, exp_sum);
    chk("R8", "id held", 32'(int_id_o), 32'(exp_id));
    @(posedge clk); @(negedge clk);
    chk("R8", "unsup clears", 32'(unsup_o), 32'h0);

    // R7: strobe with nothing pending
    strobe(32'h0000_0001, 32'h8000_0000, 32'h0, 5'd0);
    chk("R7", "no trap on empty", 32'(trap_o), 32'h0);
    chk("R7", "summary held on empty", summary_o, exp_sum);

    // R9: check flag set without strobe, cleared by strobe
    soft_req_i = 32'h0000_0008; ext_req_i = '0; async_req_i = '0; cur_ipl_i = 5'd0;
    @(posedge clk); @(negedge clk);
    chk("R9", "chk set", 32'(chk_pend_o), 32'h1);
    @(posedge clk); @(negedge clk);
    chk("R9", "chk sticky", 32'(chk_pend_o), 32'h1);
    soft_req_i = '0;
    strobe(32'h0000_0008, 32'h0, 32'h0, 5'd0);
    chk("R9", "chk cleared", 32'(chk_pend_o), 32'h0);
    chk("R1", "bit3 level", 32'(int_id_o), 32'd3);
    soft_req_i = '0;

    // R10: reset mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R10", "summary after mid reset", summary_o, 32'h0);
    chk("R10", "id after mid reset", 32'(int_id_o), 32'h0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule